// File: doc/BRIEF.md
# Device-Side Serial Keyboard/Mouse Frame Transmitter

This block is the device end of a two-wire open-drain keyboard/mouse link. It sends one byte per frame toward the host and generates the link clock itself, while the host keeps the right to stop it at any moment by holding that clock low. A client presents a byte with a one-cycle valid strobe while the block is idle. The block then waits until it has seen the clock line released for a full idle-qualification window. After that it shifts out an 11-bit frame with its own clock.

On the wire, each high and each low clock phase is a fixed number of microseconds long. Data changes only in the middle of a high phase, so it is steady while the clock is low, which is when the host samples. In every high phase the block reads the clock line back. If it finds the line low while it is not pulling it low, the host is inhibiting. The block then releases both lines at once and reports the frame as aborted. A frame that reaches its eleventh low phase is reported as done. Timing is derived from the system clock frequency parameter.

Top module: `ps2_dev_tx`

## Requirements
- R1: After reset, and whenever `tx_busy` is 0, both `ps2_clk_low` and `ps2_dat_low` are 0 and neither `tx_done` nor `tx_abort` pulses.
- R2: After a request, the block starts driving only when the synchronised clock line has read high for IDLE_US microseconds in a row. Any low reading restarts this window. With the default bench timing, the start bit appears 70 to 80 cycles after the host releases the clock.
- R3: A frame is 11 bits, each sampled while the clock is pulled low: frame bit 0 is a start bit of 0, frame bits 1 to 8 are the data byte least significant bit first, frame bit 9 is odd parity (the eight data bits plus parity hold an odd number of ones), and frame bit 10 is a stop bit of 1.
- R4: Inside a frame, every low clock phase lasts HALF_US microseconds, and every high phase except the first lasts HALF_US microseconds.
- R5: `ps2_dat_low` never changes while `ps2_clk_low` is 1. For every bit after the start bit, the data change comes DATA_US microseconds after the clock release.
- R6: If the host holds the clock low during any high phase of a frame, then within 10 cycles the block releases both lines, pulses `tx_abort` for one cycle and does not pulse `tx_done`.
- R7: After the eleventh low phase the block releases the clock, pulses `tx_done` for one cycle and drops `tx_busy`.
- R8: A `tx_valid` strobe while `tx_busy` is 1 is ignored: no further frame follows the current one.
- R9: `tx_done` and `tx_abort` are never high together, and neither stays high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_data | input | 8 | Byte to send |
| tx_valid | input | 1 | One-cycle request strobe, taken only while idle |
| ps2_clk_in | input | 1 | Sensed level of the link clock wire (asynchronous) |
| ps2_clk_low | output | 1 | Enable that pulls the link clock wire low |
| ps2_dat_low | output | 1 | Enable that pulls the link data wire low |
| tx_busy | output | 1 | A request is pending or a frame is in progress |
| tx_done | output | 1 | One-cycle pulse when a frame completes |
| tx_abort | output | 1 | One-cycle pulse when the host aborts a frame |

## Verification
The bench sends a sweep of bytes that includes all-zeros, all-ones and many mixed patterns. It rebuilds each frame from the samples taken at the clock falls. A parity or bit-order fault therefore shows up as a mismatched 11-bit word, and a phase counter that is off by one breaks the 40-cycle high and low lengths. Host inhibits are placed in the first high phase and in the middle of a frame. A design that misses the readback would keep clocking into a held line and later report done instead of abort. The idle window is tested with a release that the host cuts short. A qualifier that does not restart on a low reading would start the frame too early. A strobe offered mid-frame must not produce a second frame.

// File: rtl/ps2tx_pkg.sv
// Shared types and helpers for the device-side frame transmitter.
// Assumes: frames are 11 bits and parity is odd.
package ps2tx_pkg;

    localparam int FRAME_BITS = 11;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HOLD = 2'd1,
        ST_HIGH = 2'd2,
        ST_LOW  = 2'd3
    } tx_state_t;

    // Convert a microsecond figure into system clock cycles.
    function automatic int us_to_cyc(input int clk_hz, input int us);
        return (clk_hz / 1_000_000) * us;
    endfunction

endpackage

// File: rtl/ps2tx_sync.sv
// Multi-stage synchroniser for an asynchronous wire level.
// Assumes: the input is a slow level; resets to the released (high) level.
module ps2tx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain;

    // Shift the sensed level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], async_in};
    end

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/ps2tx_idle_qual.sv
// Counts consecutive high readings of the synchronised clock line and
// flags when the line has been released for IDLE_CYC cycles in a row.
// Assumes: line_hi is already synchronous to clk.
module ps2tx_idle_qual #(
    parameter int IDLE_CYC = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_hi,
    output logic idle_ok
);
    localparam int CW = $clog2(IDLE_CYC + 1);
    localparam logic [CW-1:0] LIMIT = CW'(IDLE_CYC);

    logic [CW-1:0] run_cnt;

    // Saturating run-length counter; any low reading restarts it.
    always_ff @(posedge clk) begin
        if (!rst_n)                run_cnt <= '0;
        else if (!line_hi)         run_cnt <= '0;
        else if (run_cnt != LIMIT) run_cnt <= run_cnt + 1'b1;
    end

    assign idle_ok = (run_cnt == LIMIT);
endmodule

// File: rtl/ps2tx_frame.sv
// Builds the 11-bit frame: start 0, data LSB first, odd parity, stop 1.
// Bit 0 of the result goes out first.
module ps2tx_frame (
    input  logic [7:0]  data,
    output logic [10:0] frame
);
    // Pack fields; parity makes the count of ones in data plus parity odd.
    always_comb frame = {1'b1, ~(^data), data, 1'b0};
endmodule

// File: rtl/ps2_dev_tx.sv
// Device-side frame transmitter for a two-wire open-drain link.
// Generates the link clock, places data mid-way through each high phase,
// watches for host inhibit during high phases, and reports done or abort.
// Assumes: the wire levels come in asynchronously; CLK_HZ is a whole
// number of MHz; DATA_US < HALF_US.
module ps2_dev_tx #(
    parameter int CLK_HZ  = 50_000_000,
    parameter int HALF_US = 40,
    parameter int DATA_US = 20,
    parameter int IDLE_US = 50,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] tx_data,
    input  logic       tx_valid,
    input  logic       ps2_clk_in,
    output logic       ps2_clk_low,
    output logic       ps2_dat_low,
    output logic       tx_busy,
    output logic       tx_done,
    output logic       tx_abort
);
    import ps2tx_pkg::*;

    localparam int HALF_CYC = us_to_cyc(CLK_HZ, HALF_US);
    localparam int OFS_CYC  = us_to_cyc(CLK_HZ, DATA_US);
    localparam int IDLE_CYC = us_to_cyc(CLK_HZ, IDLE_US);
    localparam int GUARD    = SYNC_STAGES + 1;
    localparam int PW       = $clog2(HALF_CYC + 1);
    localparam logic [PW-1:0] PH_END   = PW'(HALF_CYC - 1);
    localparam logic [PW-1:0] PH_DATA  = PW'(OFS_CYC - 1);
    localparam logic [PW-1:0] PH_GUARD = PW'(GUARD);
    localparam logic [3:0]    LAST_BIT = 4'(FRAME_BITS - 1);

    tx_state_t      state;
    logic [10:0]    frame_q;
    logic [10:0]    frame_d;
    logic [3:0]     bit_idx;
    logic [PW-1:0]  phase;
    logic           clk_sync;
    logic           idle_ok;

    ps2tx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (ps2_clk_in),
        .sync_out (clk_sync)
    );

    ps2tx_idle_qual #(.IDLE_CYC(IDLE_CYC)) u_qual (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_hi (clk_sync),
        .idle_ok (idle_ok)
    );

    ps2tx_frame u_frame (
        .data  (tx_data),
        .frame (frame_d)
    );

    // Frame sequencer: accept, qualify idle, then alternate high/low phases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            frame_q     <= '1;
            bit_idx     <= '0;
            phase       <= '0;
            ps2_clk_low <= 1'b0;
            ps2_dat_low <= 1'b0;
            tx_done     <= 1'b0;
            tx_abort    <= 1'b0;
        end else begin
            tx_done  <= 1'b0;
            tx_abort <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (tx_valid) begin
                        frame_q <= frame_d;
                        state   <= ST_HOLD;
                    end
                end
                ST_HOLD: begin
                    if (idle_ok) begin
                        state   <= ST_HIGH;
                        bit_idx <= '0;
                        phase   <= '0;
                    end
                end
                ST_HIGH: begin
                    if (phase >= PH_GUARD && !clk_sync) begin
                        ps2_dat_low <= 1'b0;
                        tx_abort    <= 1'b1;
                        state       <= ST_IDLE;
                    end else begin
                        phase <= phase + 1'b1;
                        if (phase == PH_DATA)
                            ps2_dat_low <= ~frame_q[bit_idx];
                        if (phase == PH_END) begin
                            ps2_clk_low <= 1'b1;
                            phase       <= '0;
                            state       <= ST_LOW;
                        end
                    end
                end
                ST_LOW: begin
                    phase <= phase + 1'b1;
                    if (phase == PH_END) begin
                        ps2_clk_low <= 1'b0;
                        phase       <= '0;
                        if (bit_idx == LAST_BIT) begin
                            ps2_dat_low <= 1'b0;
                            tx_done     <= 1'b1;
                            state       <= ST_IDLE;
                        end else begin
                            bit_idx <= bit_idx + 1'b1;
                            state   <= ST_HIGH;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign tx_busy = (state != ST_IDLE);
endmodule

// File: rtl/ps2_dev_tx_chk.sv
// Property checker for ps2_dev_tx, attached with bind below.
module ps2_dev_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic tx_valid,
    input logic ps2_clk_low,
    input logic ps2_dat_low,
    input logic tx_busy,
    input logic tx_done,
    input logic tx_abort
);
    // R1: an idle block leaves both wires released.
    p_idle_released_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy |-> (!ps2_clk_low && !ps2_dat_low));

    // R2: a strobe taken while idle makes the block busy.
    p_accept_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_busy && tx_valid) |=> tx_busy);

    // R5: data holds still while the clock is pulled low.
    p_dat_stable_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ps2_clk_low && $past(ps2_clk_low)) |-> $stable(ps2_dat_low));

    // R6: an abort leaves both wires released.
    p_abort_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_abort |-> (!ps2_clk_low && !ps2_dat_low && !tx_busy));

    // R7: a completed frame leaves both wires released.
    p_done_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |-> (!ps2_clk_low && !ps2_dat_low && !tx_busy));

    // R9: outcomes are exclusive and last a single cycle.
    p_outcome_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({tx_done, tx_abort}));
    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |=> !tx_done);
    p_abort_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_abort |=> !tx_abort);
endmodule

bind ps2_dev_tx ps2_dev_tx_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tx_valid    (tx_valid),
    .ps2_clk_low (ps2_clk_low),
    .ps2_dat_low (ps2_dat_low),
    .tx_busy     (tx_busy),
    .tx_done     (tx_done),
    .tx_abort    (tx_abort)
);

// File: tb/test_ps2_dev_tx.sv
`timescale 1ns/1ps
module test_ps2_dev_tx;
    // 1 MHz timing parameter so 1 cycle = 1 us in the design's arithmetic.
    localparam int HALF = 40;
    localparam int OFS  = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] tx_data = '0;
    logic       tx_valid = 1'b0;
    logic       host_hold = 1'b0;
    logic       ps2_clk_low, ps2_dat_low, tx_busy, tx_done, tx_abort;
    logic       clk_line;

    assign clk_line = ~ps2_clk_low & ~host_hold;

    ps2_dev_tx #(.CLK_HZ(1_000_000)) i_ps2_dev_tx (
        .clk         (clk),
        .rst_n       (rst_n),
        .tx_data     (tx_data),
        .tx_valid    (tx_valid),
        .ps2_clk_in  (clk_line),
        .ps2_clk_low (ps2_clk_low),
        .ps2_dat_low (ps2_dat_low),
        .tx_busy     (tx_busy),
        .tx_done     (tx_done),
        .tx_abort    (tx_abort)
    );

    always #10 clk = ~clk;

    int checks = 0;
    int fails  = 0;

    // Monitor state, owned by the monitor process only.
    int  cyc = 0;
    int  nfall = 0;
    int  ndone = 0;
    int  nabort = 0;
    int  bad_hi = 0, bad_lo = 0, bad_gap = 0, bad_chg = 0;
    int  ndchg = 0;
    int  t_rise = 0, t_fall = 0, t_dchg = 0;
    bit  rise_ok = 0;
    bit  bits_log [0:2047];
    logic prev_cl = 1'b0, prev_dl = 1'b0;

    // Watch the device outputs between clock edges and log timing.
    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (tx_done)  ndone  <= ndone + 1;
        if (tx_abort) nabort <= nabort + 1;
        if (ps2_clk_low && !prev_cl) begin
            bits_log[nfall % 2048] <= ~ps2_dat_low;
            nfall <= nfall + 1;
            t_fall <= cyc;
            if (rise_ok && (cyc - t_rise) != HALF) bad_hi <= bad_hi + 1;
        end
        if (!ps2_clk_low && prev_cl) begin
            if ((cyc - t_fall) != HALF) bad_lo <= bad_lo + 1;
            t_rise  <= cyc;
            rise_ok <= 1'b1;
        end
        if (ps2_dat_low != prev_dl) begin
            ndchg  <= ndchg + 1;
            t_dchg <= cyc;
            if (ps2_clk_low || prev_cl) bad_chg <= bad_chg + 1;
            if (rise_ok && !tx_abort && !tx_done && (cyc - t_rise) != OFS)
                bad_gap <= bad_gap + 1;
        end
        if (tx_done || tx_abort) rise_ok <= 1'b0;
        prev_cl <= ps2_clk_low;
        prev_dl <= ps2_dat_low;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic strobe(input logic [7:0] b);
        @(negedge clk);
        tx_data  = b;
        tx_valid = 1'b1;
        @(negedge clk);
        tx_valid = 1'b0;
    endtask

    task automatic wait_end(input int limit);
        int d0 = ndone + nabort;
        for (int i = 0; i < limit && (ndone + nabort) == d0; i++) @(negedge clk);
        @(negedge clk);
    endtask

    // Send one byte and check frame contents and timing (R3, R4, R5, R7).
    task automatic send_check(input logic [7:0] b);
        int f0 = nfall, d0 = ndone, h0 = bad_hi, l0 = bad_lo;
        int g0 = bad_gap, c0 = bad_chg;
        logic [10:0] exp_f, got;
        exp_f = {1'b1, ~(^b), b, 1'b0};
        strobe(b);
        wait_end(3000);
        got = '0;
        for (int k = 0; k < 11; k++) got[k] = bits_log[(f0 + k) % 2048];
        check(nfall - f0 == 11, "R3", "fall count", nfall - f0, 11);
        check(got == exp_f, "R3", "frame bits", int'(got), int'(exp_f));
        check(ndone - d0 == 1 && !tx_busy, "R7", "done pulse", ndone - d0, 1);
        check(bad_hi == h0 && bad_lo == l0, "R4", "phase length errors",
              (bad_hi - h0) + (bad_lo - l0), 0);
        check(bad_gap == g0 && bad_chg == c0, "R5", "data timing errors",
              (bad_gap - g0) + (bad_chg - c0), 0);
    endtask

    // Watchdog: a hung run is a failure and still reaches the summary.
    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int rel, f0, a0, d0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state.
        check(!ps2_clk_low && !ps2_dat_low && !tx_busy && !tx_done && !tx_abort,
              "R1", "reset outputs", int'({ps2_clk_low, ps2_dat_low, tx_busy}), 0);
        repeat (60) @(negedge clk);

        // Sweep of byte patterns (R3, R4, R5, R7).
        send_check(8'h00);
        send_check(8'hFF);
        for (int i = 0; i < 60; i++) send_check(8'((i * 37 + 5) ^ (i >> 2)));

        // R2: deferred start with an interrupted release.
        host_hold = 1'b1;
        repeat (100) @(negedge clk);
        f0 = ndchg;
        strobe(8'hA5);
        repeat (100) @(negedge clk);
        check(ndchg == f0 && !ps2_clk_low, "R2", "activity while held",
              ndchg - f0, 0);
        host_hold = 1'b0;
        repeat (30) @(negedge clk);
        host_hold = 1'b1;
        repeat (10) @(negedge clk);
        check(ndchg == f0, "R2", "start after short release", ndchg - f0, 0);
        host_hold = 1'b0;
        rel = cyc;
        for (int i = 0; i < 300 && ndchg == f0; i++) @(negedge clk);
        check((t_dchg - rel) >= 70 && (t_dchg - rel) <= 80, "R2",
              "start bit delay", t_dchg - rel, 72);
        wait_end(3000);
        repeat (60) @(negedge clk);

        // R6: inhibit in the first high phase.
        a0 = nabort; d0 = ndone;
        strobe(8'h3C);
        repeat (10) @(negedge clk);
        host_hold = 1'b1;
        repeat (10) @(negedge clk);
        check(nabort - a0 == 1 && !ps2_clk_low && !ps2_dat_low, "R6",
              "abort in first phase", nabort - a0, 1);
        repeat (150) @(negedge clk);
        check(ndone == d0 && !tx_busy, "R6", "no done after abort", ndone - d0, 0);
        host_hold = 1'b0;
        repeat (100) @(negedge clk);

        // R6: inhibit mid-frame after the fifth clock fall.
        a0 = nabort; d0 = ndone; f0 = nfall;
        strobe(8'hC3);
        for (int i = 0; i < 3000 && nfall - f0 < 5; i++) @(negedge clk);
        while (ps2_clk_low) @(negedge clk);
        repeat (10) @(negedge clk);
        host_hold = 1'b1;
        repeat (10) @(negedge clk);
        check(nabort - a0 == 1 && !ps2_clk_low && !ps2_dat_low, "R6",
              "abort mid-frame", nabort - a0, 1);
        repeat (200) @(negedge clk);
        check(ndone == d0 && nfall - f0 == 5, "R6", "frame stopped",
              nfall - f0, 5);
        host_hold = 1'b0;
        repeat (100) @(negedge clk);

        // R8: a strobe mid-frame is ignored.
        f0 = nfall;
        strobe(8'h81);
        repeat (200) @(negedge clk);
        strobe(8'h7E);
        wait_end(3000);
        repeat (400) @(negedge clk);
        check(nfall - f0 == 11 && !tx_busy, "R8", "extra frame", nfall - f0, 11);
        // R9: outcome counts consistent across the run.
        check(ndone + nabort == 66, "R9", "total outcomes", ndone + nabort, 66);
        // R1: idle afterward.
        check(!ps2_clk_low && !ps2_dat_low && !tx_busy, "R1", "idle outputs",
              int'({ps2_clk_low, ps2_dat_low}), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule